// File: doc/BRIEF.md
# Three-Stage Pipeline Hazard Controller

This block decides, every cycle, how a three-stage in-order integer pipeline moves. The stages are fetch, a combined decode/execute stage, and a memory/writeback stage. It compares the source registers of the instruction in decode/execute with the destination of the instruction in writeback. When they match, it tells the operand muxes to take the writeback result instead of the register file value. The same selects drive the ALU operand muxes and the branch comparator, so a dependent instruction never waits.

Branches are assumed not taken. When decode/execute resolves a taken branch or a jump, the block redirects the PC and replaces the instruction leaving fetch with the canonical no-op. A stall request from either cache holds the PC and every pipeline register. While a stall is active, no redirect or flush is issued. A redirect seen during a stall is remembered and carried out on the first free cycle, so no instruction is lost or issued twice.

Top module: `pipe3_hazard_unit`

## Requirements
- R1: `fwd_rs1_o` is 1 (take the writeback result) exactly when `wb_we_i` is 1, `wb_rd_i` is nonzero and `wb_rd_i` equals `idx_rs1_i`; otherwise it is 0 (take the register file).
- R2: `fwd_rs2_o` follows the same rule against `idx_rs2_i`, independently of `fwd_rs1_o`.
- R3: A writeback to register 0 is never forwarded, even when a source register is also 0 and `wb_we_i` is 1.
- R4: While `icache_stall_i` or `dcache_stall_i` is 1, `pc_en_o`, `ifidx_en_o` and `idxwb_en_o` are all 0; with neither stall set, all three are 1.
- R5: With no stall, `idx_redirect_i` = 1 raises `pc_redirect_o` and `flush_if_o` in the same cycle.
- R6: When `flush_if_o` is 1, `ifidx_insn_o` is 32'h00000013 (addi x0,x0,0); otherwise it equals `if_insn_i`.
- R7: While either stall is set, `pc_redirect_o` and `flush_if_o` stay 0.
- R8: A redirect seen in any stalled cycle makes `pc_redirect_o` and `flush_if_o` 1 in the first cycle without a stall, even if `idx_redirect_i` has dropped by then.
- R9: After reset, no remembered redirect is pending: with `idx_redirect_i` = 0 and no stall, `flush_if_o` is 0.
- R10: A remembered redirect is used once. In the cycle after it fires, with no new redirect, `flush_if_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| idx_rs1_i | input | REG_AW | First source register in decode/execute |
| idx_rs2_i | input | REG_AW | Second source register in decode/execute |
| wb_rd_i | input | REG_AW | Destination register in writeback |
| wb_we_i | input | 1 | Register write enable in writeback |
| idx_redirect_i | input | 1 | Taken branch or jump resolved in decode/execute |
| icache_stall_i | input | 1 | Instruction cache cannot answer this cycle |
| dcache_stall_i | input | 1 | Data cache cannot answer this cycle |
| if_insn_i | input | XLEN | Instruction word leaving fetch |
| fwd_rs1_o | output | 1 | Operand A / comparator A select: 1 = writeback result |
| fwd_rs2_o | output | 1 | Operand B / comparator B select: 1 = writeback result |
| pc_en_o | output | 1 | PC update enable |
| ifidx_en_o | output | 1 | Fetch-to-decode register enable |
| idxwb_en_o | output | 1 | Decode-to-writeback register enable |
| pc_redirect_o | output | 1 | Load the PC from the branch target |
| flush_if_o | output | 1 | Replace the fetched instruction with a no-op |
| ifidx_insn_o | output | XLEN | Instruction word to load into the fetch-to-decode register |

## Verification
The forwarding rule is tried with a match on one source only, a match on both, a matching destination with the write enable low, a nonmatching destination, and destination register 0 with matching zero sources. These cases separate a correct compare from one that ignores the enable, ignores register 0, or mixes up the two operands. The stall logic is tried with each cache alone and with both at once, and forwarding is checked to still work during a stall. Redirects are tried unstalled, raised during a stall and dropped before release, and followed by an idle cycle. A reset that arrives while a redirect is pending shows whether the remembered flush is cleared, carried out once, or wrongly repeated.

// File: rtl/pipe3_hz_pkg.sv
package pipe3_hz_pkg;

    localparam logic [31:0] NOP_INSN = 32'h0000_0013;

    typedef enum logic {
        SRC_REGFILE = 1'b0,
        SRC_WB      = 1'b1
    } fwd_src_e;

    typedef struct packed {
        logic pend;
    } flow_state_t;

endpackage

// File: rtl/hz_fwd_unit.sv
module hz_fwd_unit #(
    parameter int REG_AW = 5
) (
    input  logic [REG_AW-1:0]     src_reg,
    input  logic [REG_AW-1:0]     wb_rd,
    input  logic                  wb_we,
    output pipe3_hz_pkg::fwd_src_e sel
);
    import pipe3_hz_pkg::*;

    localparam logic [REG_AW-1:0] ZERO_REG = '0;

    logic rd_live;

    always_comb begin
        rd_live = wb_we && (wb_rd != ZERO_REG);
        sel     = (rd_live && (wb_rd == src_reg)) ? SRC_WB : SRC_REGFILE;
    end
endmodule

// File: rtl/hz_flow_ctrl.sv
module hz_flow_ctrl #(
    parameter int NUM_STALL = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_STALL-1:0] stall_req,
    input  logic                 redirect,
    output logic                 stage_en,
    output logic                 redirect_fire
);
    import pipe3_hz_pkg::*;

    flow_state_t st_d, st_q;
    logic        frozen;

    always_comb begin
        st_d          = st_q;
        frozen        = |stall_req;
        stage_en      = !frozen;
        redirect_fire = 1'b0;
        if (frozen) begin
            st_d.pend = st_q.pend || redirect;
        end else begin
            redirect_fire = redirect || st_q.pend;
            st_d.pend     = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/hz_insn_inject.sv
module hz_insn_inject #(
    parameter int XLEN = 32
) (
    input  logic            flush,
    input  logic [XLEN-1:0] insn_in,
    output logic [XLEN-1:0] insn_out
);
    import pipe3_hz_pkg::*;

    localparam logic [XLEN-1:0] NOP_W = XLEN'(NOP_INSN);

    always_comb begin
        insn_out = flush ? NOP_W : insn_in;
    end
endmodule

// File: rtl/pipe3_hazard_unit.sv
module pipe3_hazard_unit #(
    parameter int REG_AW = 5,
    parameter int XLEN   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] idx_rs1_i,
    input  logic [REG_AW-1:0] idx_rs2_i,
    input  logic [REG_AW-1:0] wb_rd_i,
    input  logic              wb_we_i,
    input  logic              idx_redirect_i,
    input  logic              icache_stall_i,
    input  logic              dcache_stall_i,
    input  logic [XLEN-1:0]   if_insn_i,
    output logic              fwd_rs1_o,
    output logic              fwd_rs2_o,
    output logic              pc_en_o,
    output logic              ifidx_en_o,
    output logic              idxwb_en_o,
    output logic              pc_redirect_o,
    output logic              flush_if_o,
    output logic [XLEN-1:0]   ifidx_insn_o
);
    import pipe3_hz_pkg::*;

    localparam int NUM_SRC   = 2;
    localparam int NUM_STALL = 2;

    logic [REG_AW-1:0]    src_regs [NUM_SRC];
    fwd_src_e             src_sel  [NUM_SRC];
    logic [NUM_STALL-1:0] stall_vec;
    logic                 stage_en;
    logic                 fire;

    always_comb begin
        src_regs[0] = idx_rs1_i;
        src_regs[1] = idx_rs2_i;
        stall_vec   = {dcache_stall_i, icache_stall_i};
    end

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_fwd
        hz_fwd_unit #(.REG_AW(REG_AW)) u_fwd (
            .src_reg (src_regs[s]),
            .wb_rd   (wb_rd_i),
            .wb_we   (wb_we_i),
            .sel     (src_sel[s])
        );
    end

    hz_flow_ctrl #(.NUM_STALL(NUM_STALL)) u_flow (
        .clk           (clk),
        .rst_n         (rst_n),
        .stall_req     (stall_vec),
        .redirect      (idx_redirect_i),
        .stage_en      (stage_en),
        .redirect_fire (fire)
    );

    hz_insn_inject #(.XLEN(XLEN)) u_inject (
        .flush    (fire),
        .insn_in  (if_insn_i),
        .insn_out (ifidx_insn_o)
    );

    always_comb begin
        fwd_rs1_o     = (src_sel[0] == SRC_WB);
        fwd_rs2_o     = (src_sel[1] == SRC_WB);
        pc_en_o       = stage_en;
        ifidx_en_o    = stage_en;
        idxwb_en_o    = stage_en;
        pc_redirect_o = fire;
        flush_if_o    = fire;
    end
endmodule

// File: rtl/pipe3_hazard_unit_chk.sv
module pipe3_hazard_unit_chk #(
    parameter int REG_AW = 5,
    parameter int XLEN   = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [REG_AW-1:0] idx_rs1_i,
    input logic [REG_AW-1:0] idx_rs2_i,
    input logic [REG_AW-1:0] wb_rd_i,
    input logic              wb_we_i,
    input logic              idx_redirect_i,
    input logic              icache_stall_i,
    input logic              dcache_stall_i,
    input logic              fwd_rs1_o,
    input logic              fwd_rs2_o,
    input logic              pc_en_o,
    input logic              ifidx_en_o,
    input logic              idxwb_en_o,
    input logic              pc_redirect_o,
    input logic              flush_if_o,
    input logic [XLEN-1:0]   ifidx_insn_o
);
    logic stalled;
    assign stalled = icache_stall_i || dcache_stall_i;

    p_fwd_a_match_r1: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_rs1_o |-> (wb_we_i && wb_rd_i == idx_rs1_i));

    p_fwd_b_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_rs2_o |-> (wb_we_i && wb_rd_i == idx_rs2_i));

    p_zero_reg_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_rd_i == '0) |-> (!fwd_rs1_o && !fwd_rs2_o));

    p_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
        stalled |-> (!pc_en_o && !ifidx_en_o && !idxwb_en_o));

    p_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !stalled |-> (pc_en_o && ifidx_en_o && idxwb_en_o));

    p_redirect_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_redirect_i && !stalled) |-> (pc_redirect_o && flush_if_o));

    p_nop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flush_if_o |-> (ifidx_insn_o == XLEN'(32'h0000_0013)));

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stalled |-> (!pc_redirect_o && !flush_if_o));

    p_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stalled && idx_redirect_i) |=> (stalled || flush_if_o));
endmodule

bind pipe3_hazard_unit pipe3_hazard_unit_chk #(.REG_AW(REG_AW), .XLEN(XLEN)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .idx_rs1_i      (idx_rs1_i),
    .idx_rs2_i      (idx_rs2_i),
    .wb_rd_i        (wb_rd_i),
    .wb_we_i        (wb_we_i),
    .idx_redirect_i (idx_redirect_i),
    .icache_stall_i (icache_stall_i),
    .dcache_stall_i (dcache_stall_i),
    .fwd_rs1_o      (fwd_rs1_o),
    .fwd_rs2_o      (fwd_rs2_o),
    .pc_en_o        (pc_en_o),
    .ifidx_en_o     (ifidx_en_o),
    .idxwb_en_o     (idxwb_en_o),
    .pc_redirect_o  (pc_redirect_o),
    .flush_if_o     (flush_if_o),
    .ifidx_insn_o   (ifidx_insn_o)
);

// File: tb/pipe3_hazard_unit_bench.sv
`timescale 1ns/1ps
module pipe3_hazard_unit_bench;
    localparam int REG_AW = 5;
    localparam int XLEN   = 32;
    localparam logic [31:0] NOP = 32'h0000_0013;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [REG_AW-1:0] idx_rs1_i = '0, idx_rs2_i = '0, wb_rd_i = '0;
    logic              wb_we_i = 1'b0, idx_redirect_i = 1'b0;
    logic              icache_stall_i = 1'b0, dcache_stall_i = 1'b0;
    logic [XLEN-1:0]   if_insn_i = '0;
    logic              fwd_rs1_o, fwd_rs2_o, pc_en_o, ifidx_en_o, idxwb_en_o;
    logic              pc_redirect_o, flush_if_o;
    logic [XLEN-1:0]   ifidx_insn_o;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    pipe3_hazard_unit #(.REG_AW(REG_AW), .XLEN(XLEN)) u_pipe3_hazard_unit (.*);

    // rs1, rs2, rd, we, redirect, istall, dstall | fwd1, fwd2, en, flush
    localparam int NV = 13;
    localparam logic [22:0] VEC [NV] = '{
        {5'd1,  5'd2,  5'd1,  4'b1000, 4'b1010},
        {5'd3,  5'd7,  5'd7,  4'b1000, 4'b0110},
        {5'd5,  5'd5,  5'd5,  4'b1000, 4'b1110},
        {5'd5,  5'd5,  5'd5,  4'b0000, 4'b0010},
        {5'd0,  5'd0,  5'd0,  4'b1000, 4'b0010},
        {5'd0,  5'd4,  5'd0,  4'b1000, 4'b0010},
        {5'd31, 5'd30, 5'd31, 4'b1000, 4'b1010},
        {5'd6,  5'd9,  5'd10, 4'b1000, 4'b0010},
        {5'd1,  5'd2,  5'd3,  4'b1010, 4'b0000},
        {5'd1,  5'd2,  5'd3,  4'b1001, 4'b0000},
        {5'd8,  5'd8,  5'd8,  4'b1011, 4'b1100},
        {5'd1,  5'd2,  5'd3,  4'b0100, 4'b0011},
        {5'd4,  5'd4,  5'd4,  4'b1100, 4'b1111}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive_idle();
        idx_rs1_i = 5'd1; idx_rs2_i = 5'd2; wb_rd_i = 5'd3; wb_we_i = 1'b0;
        idx_redirect_i = 1'b0; icache_stall_i = 1'b0; dcache_stall_i = 1'b0;
        if_insn_i = 32'hCAFE_0001;
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        drive_idle();
        #1;
        chk("R9 reset flush", {31'd0, flush_if_o}, 32'd0);
        chk("R9 reset redirect", {31'd0, pc_redirect_o}, 32'd0);
        chk("R4 reset enables", {29'd0, pc_en_o, ifidx_en_o, idxwb_en_o}, 32'd7);
        @(negedge clk); rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            idx_rs1_i      = VEC[i][22:18];
            idx_rs2_i      = VEC[i][17:13];
            wb_rd_i        = VEC[i][12:8];
            wb_we_i        = VEC[i][7];
            idx_redirect_i = VEC[i][6];
            icache_stall_i = VEC[i][5];
            dcache_stall_i = VEC[i][4];
            if_insn_i      = 32'hDEAD_0000 + 32'(i);
            #1;
            chk("R1 R3 fwd_rs1", {31'd0, fwd_rs1_o}, {31'd0, VEC[i][3]});
            chk("R2 R3 fwd_rs2", {31'd0, fwd_rs2_o}, {31'd0, VEC[i][2]});
            chk("R4 enables", {29'd0, pc_en_o, ifidx_en_o, idxwb_en_o},
                VEC[i][1] ? 32'd7 : 32'd0);
            chk("R5 R7 flush", {31'd0, flush_if_o}, {31'd0, VEC[i][0]});
            chk("R5 R7 redirect", {31'd0, pc_redirect_o}, {31'd0, VEC[i][0]});
            chk("R6 insn", ifidx_insn_o, VEC[i][0] ? NOP : 32'hDEAD_0000 + 32'(i));
        end

        // R8: redirect raised under a stall, dropped before release
        @(negedge clk); drive_idle(); icache_stall_i = 1'b1; idx_redirect_i = 1'b1; #1;
        chk("R7 stalled redirect", {31'd0, flush_if_o}, 32'd0);
        @(negedge clk); idx_redirect_i = 1'b0; icache_stall_i = 1'b0; dcache_stall_i = 1'b1; #1;
        chk("R7 still stalled", {31'd0, pc_redirect_o}, 32'd0);
        @(negedge clk); dcache_stall_i = 1'b0; #1;
        chk("R8 pending flush", {31'd0, flush_if_o}, 32'd1);
        chk("R8 pending redirect", {31'd0, pc_redirect_o}, 32'd1);
        chk("R6 R8 nop", ifidx_insn_o, NOP);
        @(negedge clk); #1;
        chk("R10 consumed", {31'd0, flush_if_o}, 32'd0);
        chk("R10 insn passes", ifidx_insn_o, 32'hCAFE_0001);

        // R9: reset while a redirect is pending
        @(negedge clk); dcache_stall_i = 1'b1; idx_redirect_i = 1'b1;
        @(negedge clk); idx_redirect_i = 1'b0; rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1; dcache_stall_i = 1'b0; #1;
        chk("R9 pending cleared", {31'd0, flush_if_o}, 32'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule